// File: doc/BRIEF.md
# Ethernet Receive Destination and Length/Type Filter

This block sits on the receive path of an Ethernet MAC and decides, frame by frame, whether an incoming frame should be handed to the receive buffer. Frame bytes arrive one per cycle, starting just after the start-of-frame delimiter. The first byte is qualified by a start pulse. The block records the destination address and the length/type field. It checks them against a bank of programmable destination-address slots and a bank of length/type match registers, then issues a single registered decision per frame.

Each address slot has a lower word and an upper word. Writing the upper word arms the slot. Writing the lower word disarms it, so software reprograms a slot by writing the lower word first and the upper word last. Each length/type register carries its own enable bit. The frame is accepted when any armed slot or any enabled type register matches. A configuration bit decides whether frames that arrive while the local transmitter is busy in half duplex are dropped. Alongside the accept strobe, the block reports which bank matched, the index of the matching type register, and whether the destination is a group address or broadcast.

Top module: `rx_addr_type_filter`

## Requirements
- R1: After reset every address slot is disarmed, every type register is disabled with value zero, and all outputs are 0. A frame whose destination and type are all zero is therefore not accepted.
- R2: Destination byte k (k = 0..5, counted from the first byte after the delimiter) is compared with bits 8k+7:8k of the 48-bit slot address. Bits 31:0 of the lower word hold bytes 0..3, and bits 15:0 of the upper word hold bytes 4..5. The lower word 0x87654321 with the upper word 0x0000CBA9 matches the byte sequence 21 43 65 87 A9 CB.
- R3: Writing a slot's lower word disarms that slot, and writing its upper word arms it. A disarmed slot never produces an address hit. On wr_addr, bit 3 = 0 selects the address bank, bits 2:1 select the slot, and bit 0 = 1 selects the upper word.
- R4: A type register is written with wr_addr bit 3 = 1, bit 2 = 0 and bits 1:0 as its index. Data bits 15:0 give the compare value and data bit 31 is the enable. An enabled register matches when frame byte 12 equals value bits 15:8 and frame byte 13 equals value bits 7:0.
- R5: accept is 1 exactly when the decision strobe is high, there is an address hit or a type hit (logical OR), and the frame was not dropped under R7.
- R6: When several enabled type registers match, type_idx reports the lowest index. When there is no type hit, type_idx is 0.
- R7: If cfg_hd_override is 0 and tx_half_duplex_busy is 1 in the cycle that carries destination byte 5, the frame is not accepted, although its flags are still reported. With cfg_hd_override at 1, or with the busy signal low in that cycle, the frame is not dropped.
- R8: dec_valid pulses for one cycle, in the cycle right after frame byte 13 is received, and never at any other time. The flags are 0 outside that cycle.
- R9: rx_valid together with rx_sof starts a new frame at byte 0 and discards all state of the previous frame. A frame that stops before byte 13 produces no decision. Bytes with no frame started since reset produce none either.
- R10: dst_group equals bit 0 of destination byte 0, and dst_bcast is 1 only when all 48 destination bits are 1. Both are reported with the decision strobe.
- R11: Register writes in the same cycle as byte 13 do not affect that frame's decision. The decision uses the register contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register word select (see R3, R4) |
| wr_data | input | 32 | Register write data |
| cfg_hd_override | input | 1 | 1 = keep frames received while transmitting in half duplex |
| tx_half_duplex_busy | input | 1 | Transmitter active in half-duplex mode |
| rx_valid | input | 1 | rx_data carries a frame byte |
| rx_sof | input | 1 | Qualifies the byte as frame byte 0 |
| rx_data | input | 8 | Received byte |
| dec_valid | output | 1 | One-cycle decision strobe |
| accept | output | 1 | Frame accepted |
| addr_hit | output | 1 | An armed address slot matched |
| type_hit | output | 1 | An enabled type register matched |
| type_idx | output | 2 | Lowest matching type register |
| dst_group | output | 1 | Destination is a group address |
| dst_bcast | output | 1 | Destination is broadcast |

## Verification
The bench builds the block with its default of four slots per bank, which makes wr_addr four bits wide. This lets every slot of both banks be reached, including the top slot of each. With four type registers, the bench can program overlapping values at indices 1, 2 and 3 and observe the lowest-index priority. The 14-byte decision point sits well inside the counter range, so the bench can drive short frames, restarted frames and long frames that run past the decision without the counter ever wrapping.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int MAC_BYTES   = 6;
  localparam int MAC_W       = 8 * MAC_BYTES;
  localparam int TYPE_HI_POS = 12;
  localparam int TYPE_LO_POS = TYPE_HI_POS + 1;
  localparam int WORD_W      = 32;
  localparam int ETYPE_W     = 16;
  localparam int EN_BIT      = 31;

  typedef logic [MAC_W-1:0]   mac_t;
  typedef logic [ETYPE_W-1:0] etype_t;
endpackage

// File: rtl/rxf_slot_bank.sv
module rxf_slot_bank
  import rxf_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  localparam int IW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [IW+1:0]                wr_addr,
  input  logic [WORD_W-1:0]            wr_data,
  output mac_t   [NUM_SLOTS-1:0]       slot_mac,
  output logic   [NUM_SLOTS-1:0]       slot_armed,
  output etype_t [NUM_SLOTS-1:0]       type_val,
  output logic   [NUM_SLOTS-1:0]       type_en
);
  logic addr_bank, type_bank, upper_sel;
  assign addr_bank = wr_en && !wr_addr[IW+1];
  assign type_bank = wr_en &&  wr_addr[IW+1] && !wr_addr[IW];
  assign upper_sel = wr_addr[0];

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic hit_a, hit_t;
    assign hit_a = addr_bank && (wr_addr[IW:1] == IW'(i));
    assign hit_t = type_bank && (wr_addr[IW-1:0] == IW'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        slot_mac[i]   <= '0;
        slot_armed[i] <= 1'b0;
        type_val[i]   <= '0;
        type_en[i]    <= 1'b0;
      end else begin
        if (hit_a && !upper_sel) begin
          slot_mac[i][WORD_W-1:0] <= wr_data;
          slot_armed[i]           <= 1'b0;
        end
        if (hit_a && upper_sel) begin
          slot_mac[i][MAC_W-1:WORD_W] <= wr_data[MAC_W-WORD_W-1:0];
          slot_armed[i]               <= 1'b1;
        end
        if (hit_t) begin
          type_val[i] <= wr_data[ETYPE_W-1:0];
          type_en[i]  <= wr_data[EN_BIT];
        end
      end
    end

    p_lower_disarms_r3: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !wr_addr[IW+1] && wr_addr[IW:1] == IW'(i) && !wr_addr[0]) |=> !slot_armed[i]);
    p_upper_arms_r3: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !wr_addr[IW+1] && wr_addr[IW:1] == IW'(i) && wr_addr[0]) |=> slot_armed[i]);
    p_type_enable_r4: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr[IW+1] && !wr_addr[IW] && wr_addr[IW-1:0] == IW'(i))
        |=> (type_en[i] == $past(wr_data[EN_BIT])));
  end
endmodule

// File: rtl/rxf_frame_track.sv
module rxf_frame_track
  import rxf_pkg::*;
#(
  localparam int CW = $clog2(TYPE_LO_POS + 2)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_valid,
  input  logic       rx_sof,
  input  logic [7:0] rx_data,
  input  logic       tx_busy,
  input  logic       hd_override,
  output mac_t       dst_mac,
  output logic [7:0] type_hi,
  output logic       at_type_lo,
  output logic       hd_drop
);
  localparam logic [CW-1:0] IDLE = '1;

  logic [CW-1:0] cnt, idx;
  assign idx        = rx_sof ? '0 : cnt;
  assign at_type_lo = rx_valid && (idx == CW'(TYPE_LO_POS));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= IDLE;
      type_hi <= '0;
      hd_drop <= 1'b0;
    end else if (rx_valid) begin
      if (idx != IDLE) cnt <= idx + 1'b1;
      if (idx == CW'(TYPE_HI_POS)) type_hi <= rx_data;
      if (idx == '0) hd_drop <= 1'b0;
      if (idx == CW'(MAC_BYTES - 1)) hd_drop <= tx_busy && !hd_override;
    end
  end

  for (genvar b = 0; b < MAC_BYTES; b++) begin : g_da
    always_ff @(posedge clk) begin
      if (rst) dst_mac[8*b +: 8] <= '0;
      else if (rx_valid && idx == CW'(b)) dst_mac[8*b +: 8] <= rx_data;
    end
  end

  p_sof_restarts_r9: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_sof) |=> (cnt == CW'(1)));
  p_busy_drops_r7: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_sof && cnt == CW'(MAC_BYTES - 1) && tx_busy && !hd_override) |=> hd_drop);
endmodule

// File: rtl/rxf_match.sv
module rxf_match
  import rxf_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  localparam int IW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  mac_t                   dst_mac,
  input  logic [7:0]             type_hi,
  input  logic [7:0]             type_lo,
  input  mac_t   [NUM_SLOTS-1:0] slot_mac,
  input  logic   [NUM_SLOTS-1:0] slot_armed,
  input  etype_t [NUM_SLOTS-1:0] type_val,
  input  logic   [NUM_SLOTS-1:0] type_en,
  output logic                   addr_hit,
  output logic                   type_hit,
  output logic   [IW-1:0]        type_idx
);
  logic [NUM_SLOTS-1:0] a_vec, t_vec;
  etype_t frame_type;
  assign frame_type = {type_hi, type_lo};

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_cmp
    assign a_vec[i] = slot_armed[i] && (slot_mac[i] == dst_mac);
    assign t_vec[i] = type_en[i] && (type_val[i] == frame_type);
  end

  assign addr_hit = |a_vec;
  assign type_hit = |t_vec;

  always_comb begin
    type_idx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--)
      if (t_vec[i]) type_idx = IW'(i);
  end
endmodule

// File: rtl/rx_addr_type_filter.sv
module rx_addr_type_filter
  import rxf_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  localparam int IW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IW+1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              cfg_hd_override,
  input  logic              tx_half_duplex_busy,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic [7:0]        rx_data,
  output logic              dec_valid,
  output logic              accept,
  output logic              addr_hit,
  output logic              type_hit,
  output logic [IW-1:0]     type_idx,
  output logic              dst_group,
  output logic              dst_bcast
);
  mac_t   [NUM_SLOTS-1:0] slot_mac;
  logic   [NUM_SLOTS-1:0] slot_armed;
  etype_t [NUM_SLOTS-1:0] type_val;
  logic   [NUM_SLOTS-1:0] type_en;

  mac_t       dst_mac;
  logic [7:0] type_hi;
  logic       at_type_lo, hd_drop;
  logic       m_addr, m_type;
  logic [IW-1:0] m_idx;

  rxf_slot_bank #(.NUM_SLOTS(NUM_SLOTS)) u_bank (
    .clk, .rst, .wr_en, .wr_addr, .wr_data,
    .slot_mac, .slot_armed, .type_val, .type_en
  );

  rxf_frame_track u_track (
    .clk, .rst, .rx_valid, .rx_sof, .rx_data,
    .tx_busy(tx_half_duplex_busy), .hd_override(cfg_hd_override),
    .dst_mac, .type_hi, .at_type_lo, .hd_drop
  );

  rxf_match #(.NUM_SLOTS(NUM_SLOTS)) u_match (
    .dst_mac, .type_hi, .type_lo(rx_data),
    .slot_mac, .slot_armed, .type_val, .type_en,
    .addr_hit(m_addr), .type_hit(m_type), .type_idx(m_idx)
  );

  always_ff @(posedge clk) begin
    if (rst || !at_type_lo) begin
      dec_valid <= 1'b0;
      accept    <= 1'b0;
      addr_hit  <= 1'b0;
      type_hit  <= 1'b0;
      type_idx  <= '0;
      dst_group <= 1'b0;
      dst_bcast <= 1'b0;
    end else begin
      dec_valid <= 1'b1;
      accept    <= (m_addr || m_type) && !hd_drop;
      addr_hit  <= m_addr;
      type_hit  <= m_type;
      type_idx  <= m_idx;
      dst_group <= dst_mac[0];
      dst_bcast <= &dst_mac;
    end
  end

  p_strobe_after_byte_r8: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> $past(rx_valid));
  p_single_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> !dec_valid);
  p_accept_needs_hit_r5: assert property (@(posedge clk) disable iff (rst)
    accept |-> (dec_valid && (addr_hit || type_hit)));
  p_idx_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !type_hit |-> (type_idx == '0));
  p_bcast_is_group_r10: assert property (@(posedge clk) disable iff (rst)
    dst_bcast |-> (dst_group && dec_valid));
endmodule

// File: tb/rx_addr_type_filter_tb.sv
`timescale 1ns/1ps
module rx_addr_type_filter_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic        wr_en = 0;
  logic [3:0]  wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic        cfg_hd_override = 0;
  logic        tx_half_duplex_busy = 0;
  logic        rx_valid = 0;
  logic        rx_sof = 0;
  logic [7:0]  rx_data = 0;
  logic        dec_valid, accept, addr_hit, type_hit, dst_group, dst_bcast;
  logic [1:0]  type_idx;

  always #2 clk = ~clk;

  rx_addr_type_filter u_dut (
    .clk, .rst, .wr_en, .wr_addr, .wr_data, .cfg_hd_override,
    .tx_half_duplex_busy, .rx_valid, .rx_sof, .rx_data,
    .dec_valid, .accept, .addr_hit, .type_hit, .type_idx, .dst_group, .dst_bcast
  );

  int vectors = 0, miscompares = 0;
  bit done = 0;

  // reference model state
  logic [31:0] m_lo [4];
  logic [15:0] m_hi [4];
  bit          m_arm [4];
  logic [15:0] m_tv [4];
  bit          m_ten [4];
  int          m_cnt = -1;
  logic [7:0]  m_da [6];
  logic [7:0]  m_t12;
  bit          m_drop;
  logic [6:0]  exp_v;  // {dec,acc,ah,th,idx[1:0]... packed below}
  logic [1:0]  exp_idx;

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_lo[i] = 0; m_hi[i] = 0; m_arm[i] = 0; m_tv[i] = 0; m_ten[i] = 0;
    end
    for (int i = 0; i < 6; i++) m_da[i] = 0;
    m_cnt = -1; m_t12 = 0; m_drop = 0;
  endtask

  task automatic step(input string tag);
    int idx;
    bit e_dec, e_acc, e_ah, e_th, e_g, e_b;
    logic [1:0] e_idx;
    logic [47:0] mac;
    e_dec = 0; e_acc = 0; e_ah = 0; e_th = 0; e_g = 0; e_b = 0; e_idx = 0;
    idx = rx_sof ? 0 : m_cnt;
    if (rst) begin
      model_reset();
    end else begin
      if (rx_valid && idx == 13) begin
        mac = {m_da[5], m_da[4], m_da[3], m_da[2], m_da[1], m_da[0]};
        for (int i = 0; i < 4; i++)
          if (m_arm[i] && mac == {m_hi[i], m_lo[i]}) e_ah = 1;
        for (int i = 3; i >= 0; i--)
          if (m_ten[i] && m_tv[i] == {m_t12, rx_data}) begin e_th = 1; e_idx = 2'(i); end
        e_dec = 1;
        e_acc = (e_ah || e_th) && !m_drop;
        e_g = mac[0];
        e_b = (mac == '1);
      end
      if (rx_valid && idx >= 0) begin
        if (idx < 6) m_da[idx] = rx_data;
        if (idx == 12) m_t12 = rx_data;
        if (idx == 0) m_drop = 0;
        if (idx == 5) m_drop = tx_half_duplex_busy && !cfg_hd_override;
        m_cnt = (idx > 1000) ? idx : idx + 1;
      end
      if (wr_en) begin
        if (!wr_addr[3]) begin
          if (wr_addr[0]) begin m_hi[wr_addr[2:1]] = wr_data[15:0]; m_arm[wr_addr[2:1]] = 1; end
          else begin m_lo[wr_addr[2:1]] = wr_data; m_arm[wr_addr[2:1]] = 0; end
        end else if (!wr_addr[2]) begin
          m_tv[wr_addr[1:0]] = wr_data[15:0];
          m_ten[wr_addr[1:0]] = wr_data[31];
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    vectors++;
    if ({dec_valid, accept, addr_hit, type_hit, type_idx, dst_group, dst_bcast} !==
        {e_dec, e_acc, e_ah, e_th, e_idx, e_g, e_b}) begin
      miscompares++;
      $display("FAIL %s: got dec=%0b acc=%0b ah=%0b th=%0b idx=%0d grp=%0b bc=%0b, expected dec=%0b acc=%0b ah=%0b th=%0b idx=%0d grp=%0b bc=%0b",
               tag, dec_valid, accept, addr_hit, type_hit, type_idx, dst_group, dst_bcast,
               e_dec, e_acc, e_ah, e_th, e_idx, e_g, e_b);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input string tag);
    wr_en = 1; wr_addr = a; wr_data = d;
    step(tag);
    wr_en = 0;
  endtask

  // len bytes; busy_at raises tx busy on that byte; gap_at inserts an idle cycle before that byte
  task automatic frame(input logic [47:0] da, input logic [15:0] ty, input int len,
                       input int busy_at, input int gap_at, input string tag);
    for (int b = 0; b < len; b++) begin
      if (b == gap_at) begin rx_valid = 0; step(tag); end
      rx_valid = 1;
      rx_sof = (b == 0);
      tx_half_duplex_busy = (b == busy_at);
      if (b < 6) rx_data = da[8*b +: 8];
      else if (b == 12) rx_data = ty[15:8];
      else if (b == 13) rx_data = ty[7:0];
      else rx_data = 8'(8'h30 + b);
      step(tag);
    end
    rx_valid = 0; rx_sof = 0; tx_half_duplex_busy = 0; rx_data = 0;
    step(tag);
    step(tag);
  endtask

  localparam logic [47:0] MAC_A = 48'hCBA9_8765_4321; // bytes 21 43 65 87 A9 CB

  initial begin
    @(negedge clk);
    step("R1");
    step("R1");
    rst = 0;
    step("R1");
    // R1: reset state, zero frame must be rejected
    frame(48'h0, 16'h0000, 16, -1, -1, "R1");
    // R9: bytes without any start pulse
    rx_valid = 1; rx_data = 8'h21;
    for (int k = 0; k < 16; k++) step("R9");
    rx_valid = 0; step("R9");
    // R2: program slot 1 and match the example address
    wr(4'b0010, 32'h8765_4321, "R2");
    wr(4'b0011, 32'h0000_CBA9, "R2");
    frame(MAC_A, 16'h0800, 14, -1, -1, "R2");
    frame(MAC_A ^ 48'h01_0000_0000, 16'h0800, 14, -1, -1, "R2");
    // R3: lower word write disarms, upper rearms
    wr(4'b0010, 32'h8765_4321, "R3");
    frame(MAC_A, 16'h0800, 14, -1, -1, "R3");
    wr(4'b0011, 32'h0000_CBA9, "R3");
    frame(MAC_A, 16'h0800, 15, -1, 7, "R3");
    // R3: highest slot
    wr(4'b0110, 32'h0403_0201, "R3");
    wr(4'b0111, 32'h1234_0605, "R3");
    frame(48'h0605_0403_0201, 16'h1111, 14, -1, -1, "R3");
    // R4: type register disabled then enabled
    wr(4'b1010, 32'h0000_4321, "R4");
    frame(48'h0000_0000_0002, 16'h4321, 14, -1, -1, "R4");
    wr(4'b1010, 32'h8000_4321, "R4");
    frame(48'h0000_0000_0002, 16'h4321, 14, -1, -1, "R4");
    frame(48'h0000_0000_0002, 16'h2143, 14, -1, -1, "R4");
    // R4: write to the unmapped type range is ignored
    wr(4'b1100, 32'h8000_5555, "R4");
    frame(48'h0000_0000_0002, 16'h5555, 14, -1, -1, "R4");
    // R6: priority among several matching type registers
    wr(4'b1011, 32'h8000_4321, "R6");
    frame(48'h0000_0000_0002, 16'h4321, 14, -1, -1, "R6");
    wr(4'b1001, 32'h8000_4321, "R6");
    frame(48'h0000_0000_0002, 16'h4321, 14, -1, -1, "R6");
    // R5: both sources at once
    frame(MAC_A, 16'h4321, 14, -1, -1, "R5");
    // R7: half-duplex drop
    frame(MAC_A, 16'h4321, 14, 5, -1, "R7");
    frame(MAC_A, 16'h4321, 14, 4, -1, "R7");
    cfg_hd_override = 1;
    frame(MAC_A, 16'h4321, 14, 5, -1, "R7");
    cfg_hd_override = 0;
    // R9: short frame then restart mid-frame
    frame(MAC_A, 16'h4321, 11, -1, -1, "R9");
    frame(MAC_A, 16'h4321, 9, -1, -1, "R9");
    frame(48'h0000_0000_0002, 16'h4321, 14, -1, -1, "R9");
    // R10: broadcast and multicast flags
    frame(48'hFFFF_FFFF_FFFF, 16'h0806, 14, -1, -1, "R10");
    frame(48'h5E00_0000_0001, 16'h0800, 14, -1, -1, "R10");
    frame(48'hFFFF_FFFF_FFFE, 16'h0800, 14, -1, -1, "R10");
    // R8/R11: write during byte 13 uses old contents
    for (int b = 0; b < 14; b++) begin
      rx_valid = 1; rx_sof = (b == 0);
      rx_data = (b < 6) ? 8'h02 * (b == 0) : (b == 12) ? 8'h77 : (b == 13) ? 8'h88 : 8'h00;
      if (b == 13) begin wr_en = 1; wr_addr = 4'b1000; wr_data = 32'h8000_7788; end
      step("R11");
      wr_en = 0;
    end
    rx_valid = 0; rx_sof = 0;
    step("R8");
    frame(48'h0000_0000_0002, 16'h7788, 14, -1, -1, "R11");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule